// File: doc/BRIEF.md
# Serial Rate Search Lock Controller

This block is the digital controller beside the clock-recovery loop of a multi-rate serial video receiver. It runs from a fixed reference clock. Through `div_sel` it tells the oscillator divider which line rate to try. It then counts the pulses of the divided oscillator clock over a gate of a fixed number of reference cycles. It compares that count with the expected value for the rate being tried. A count close to the expected value declares lock. Once locked, the block keeps lock until the count moves clearly away from the expected value.

There are two modes. In automatic mode the block steps through the six supported rates in a fixed order. It can leave out the 177 Mb/s step, which keeps a data stream whose idle pattern carries a harmonic near that rate from producing a false lock. In manual mode only the rate given on `man_code` is tried, and the rate-code output repeats that input. A flag tells the output driver whether the rate being tried or held is the HD rate.

Both windows are inclusive. Lock is taken when the count lies in [E − E·LOCK_PCT/100, E + E·LOCK_PCT/100]. Lock is dropped when the count falls below E − E·UNLOCK_PCT/100 or rises above E + E·UNLOCK_PCT/100. Each bound is computed in integer division, and E is the expected count of the selected rate.

Top module: `rate_lock_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block sets `lock`=0, `div_sel`=000 and the held locked code to 000. With `auto_mode` high, this gives `code_out`=000 and `sd_flag`=1.
- R2: The rate codes are 000=143, 001=177, 010=270, 011=360, 100=540 and 101=1485/1483.5 Mb/s. In automatic mode, when no rate locks, `div_sel` steps 000,001,010,011,100,101 and then wraps to 000.
- R3: In automatic mode with `skip_177` high, the step after 000 is 010. Code 001 is never reported as locked: a lock held at 001 drops on the next cycle. In manual mode `skip_177` has no effect.
- R4: At the end of each gate of GATE_CYC cycles, an unlocked block declares lock if the pulse count lies inside the 1% window of the selected rate. A count outside that window does not lock. The expected counts default to 400+20·code.
- R5: A locked block keeps lock while the gate count stays inside the 2% window. The block drops lock at the end of the first gate whose count falls outside that window. Search then resumes from the same rate.
- R6: In manual mode `div_sel` follows `man_code` one cycle later, with codes 110 and 111 tried as 000. The block never steps to another rate, and `code_out` equals `man_code`.
- R7: In automatic mode `code_out` shows the code that last locked. It keeps that value while the block searches.
- R8: `sd_flag` is 0 when `div_sel` is 101 and 1 for every other code.
- R9: In automatic mode, an unlocked rate is kept for DWELL complete gates before the search advances. With the defaults this is 2000 cycles per step.
- R10: A change of `auto_mode`, or a change of `man_code` in manual mode, drops `lock` on the next clock edge and starts a fresh gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| osc_pulse | input | 1 | One-cycle strobe per divided-oscillator period, synchronous to clk |
| auto_mode | input | 1 | 1 = automatic search, 0 = manual forced rate |
| man_code | input | 3 | Forced rate code in manual mode |
| skip_177 | input | 1 | Removes the 177 Mb/s step from the automatic search |
| div_sel | output | 3 | Rate currently tried or held; selects the oscillator divider |
| code_out | output | 3 | Automatic mode: last locked code; manual mode: copy of man_code |
| lock | output | 1 | Lock detect, active high |
| sd_flag | output | 1 | 0 for the HD rate, 1 for the SD rates |

## Verification
The assertions assume that `osc_pulse` is a clean single-cycle strobe already synchronous to the reference clock. They also assume that the mode and manual-code inputs change only between clock edges. The bench meets these conditions by driving every input on the falling edge. Its oscillator model is a phase accumulator that follows `div_sel`. The model gives a gate count within one pulse of the intended value. Each offset it applies sits at least two counts away from a window bound, so counting phase cannot move a result across a bound.

// File: rtl/rls_pkg.sv
package rls_pkg;
  localparam int RW    = 3;
  localparam int NRATE = 6;
  typedef logic [RW-1:0] rate_t;
  localparam rate_t CODE_143  = 3'd0;
  localparam rate_t CODE_177  = 3'd1;
  localparam rate_t CODE_270  = 3'd2;
  localparam rate_t CODE_HD   = 3'd5;

  // Next step of the automatic search, with optional removal of 177.
  function automatic rate_t next_rate(input rate_t cur, input logic skip);
    rate_t n;
    if (cur >= CODE_HD) n = CODE_143;
    else                n = cur + 3'd1;
    if (skip && n == CODE_177) n = CODE_270;
    return n;
  endfunction

  // Manual codes beyond the table fall back to the lowest rate.
  function automatic rate_t clamp_code(input rate_t c);
    return (c > CODE_HD) ? CODE_143 : c;
  endfunction
endpackage

// File: rtl/rls_gate_meter.sv
module rls_gate_meter #(
  parameter int GATE_CYC = 1000,
  parameter int CW       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          pulse,
  output logic          meas_valid,
  output logic [CW-1:0] meas_count
);
  localparam int GW = (GATE_CYC > 1) ? $clog2(GATE_CYC) : 1;
  localparam logic [GW-1:0] LAST = GW'(GATE_CYC - 1);

  logic [GW-1:0] gate_q;
  logic [CW-1:0] pcnt_q;

  assign meas_valid = (gate_q == LAST) && !restart;
  assign meas_count = pcnt_q + CW'(pulse);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      gate_q <= '0;
      pcnt_q <= '0;
    end else if (gate_q == LAST) begin
      gate_q <= '0;
      pcnt_q <= '0;
    end else begin
      gate_q <= gate_q + 1'b1;
      pcnt_q <= meas_count;
    end
  end
endmodule

// File: rtl/rls_window.sv
module rls_window
  import rls_pkg::*;
#(
  parameter int                CW         = 16,
  parameter logic [NRATE*CW-1:0] EXP_COUNTS = '0,
  parameter int                LOCK_PCT   = 1,
  parameter int                UNLOCK_PCT = 2
) (
  input  rate_t         sel,
  input  logic [CW-1:0] count,
  output logic          in_tight,
  output logic          out_wide
);
  localparam int NSLOT = 1 << RW;
  logic [NSLOT-1:0] tight_v;
  logic [NSLOT-1:0] wide_v;

  for (genvar i = 0; i < NSLOT; i++) begin : g_rate
    if (i < NRATE) begin : g_real
      localparam int EXPV = int'(EXP_COUNTS[i*CW +: CW]);
      localparam logic [CW-1:0] TLO = CW'(EXPV - EXPV * LOCK_PCT / 100);
      localparam logic [CW-1:0] THI = CW'(EXPV + EXPV * LOCK_PCT / 100);
      localparam logic [CW-1:0] WLO = CW'(EXPV - EXPV * UNLOCK_PCT / 100);
      localparam logic [CW-1:0] WHI = CW'(EXPV + EXPV * UNLOCK_PCT / 100);
      assign tight_v[i] = (count >= TLO) && (count <= THI);
      assign wide_v[i]  = (count < WLO) || (count > WHI);
    end else begin : g_pad
      assign tight_v[i] = 1'b0;
      assign wide_v[i]  = 1'b1;
    end
  end

  assign in_tight = tight_v[sel];
  assign out_wide = wide_v[sel];
endmodule

// File: rtl/rls_search_fsm.sv
module rls_search_fsm
  import rls_pkg::*;
#(
  parameter int DWELL = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  auto_mode,
  input  rate_t man_code,
  input  logic  skip_177,
  input  logic  meas_valid,
  input  logic  in_tight,
  input  logic  out_wide,
  output rate_t idx,
  output logic  locked,
  output rate_t last_code,
  output logic  restart
);
  localparam int MW = (DWELL > 1) ? $clog2(DWELL) : 1;
  localparam logic [MW-1:0] MISS_LAST = MW'(DWELL - 1);

  logic          auto_q;
  rate_t         man_q;
  logic [MW-1:0] miss_q;
  logic          barred;

  assign restart = (auto_mode != auto_q) || (!auto_mode && man_code != man_q);
  assign barred  = auto_mode && skip_177 && (idx == CODE_177);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx       <= CODE_143;
      locked    <= 1'b0;
      last_code <= CODE_143;
      miss_q    <= '0;
      auto_q    <= auto_mode;
      man_q     <= man_code;
    end else begin
      auto_q <= auto_mode;
      man_q  <= man_code;
      if (!auto_mode) idx <= clamp_code(man_code);
      if (restart) begin
        locked <= 1'b0;
        miss_q <= '0;
      end else if (locked) begin
        if (barred) begin
          locked <= 1'b0;
          miss_q <= '0;
          idx    <= next_rate(idx, skip_177);
        end else if (meas_valid && out_wide) begin
          locked <= 1'b0;
          miss_q <= '0;
        end
      end else if (meas_valid) begin
        if (in_tight && !barred) begin
          locked <= 1'b1;
          miss_q <= '0;
          if (auto_mode) last_code <= idx;
        end else if (miss_q == MISS_LAST) begin
          miss_q <= '0;
          if (auto_mode) idx <= next_rate(idx, skip_177);
        end else begin
          miss_q <= miss_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rate_lock_ctrl.sv
module rate_lock_ctrl
  import rls_pkg::*;
#(
  parameter int                  GATE_CYC   = 1000,
  parameter int                  DWELL      = 2,
  parameter int                  CW         = 16,
  parameter logic [NRATE*CW-1:0] EXP_COUNTS = {16'd500, 16'd480, 16'd460,
                                               16'd440, 16'd420, 16'd400},
  parameter int                  LOCK_PCT   = 1,
  parameter int                  UNLOCK_PCT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_pulse,
  input  logic       auto_mode,
  input  logic [2:0] man_code,
  input  logic       skip_177,
  output logic [2:0] div_sel,
  output logic [2:0] code_out,
  output logic       lock,
  output logic       sd_flag
);
  logic          restart;
  logic          meas_valid;
  logic [CW-1:0] meas_count;
  logic          in_tight;
  logic          out_wide;
  rate_t         idx;
  rate_t         last_code;
  logic          locked;

  rls_gate_meter #(.GATE_CYC(GATE_CYC), .CW(CW)) u_meter (
    .clk(clk), .rst_n(rst_n), .restart(restart), .pulse(osc_pulse),
    .meas_valid(meas_valid), .meas_count(meas_count)
  );

  rls_window #(.CW(CW), .EXP_COUNTS(EXP_COUNTS), .LOCK_PCT(LOCK_PCT),
               .UNLOCK_PCT(UNLOCK_PCT)) u_window (
    .sel(idx), .count(meas_count), .in_tight(in_tight), .out_wide(out_wide)
  );

  rls_search_fsm #(.DWELL(DWELL)) u_fsm (
    .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .man_code(man_code),
    .skip_177(skip_177), .meas_valid(meas_valid), .in_tight(in_tight),
    .out_wide(out_wide), .idx(idx), .locked(locked), .last_code(last_code),
    .restart(restart)
  );

  assign div_sel  = idx;
  assign lock     = locked;
  assign code_out = auto_mode ? last_code : man_code;
  assign sd_flag  = (idx != CODE_HD);
endmodule

// File: rtl/rls_checker.sv
module rls_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       auto_mode,
  input logic [2:0] man_code,
  input logic       skip_177,
  input logic [2:0] div_sel,
  input logic [2:0] code_out,
  input logic       lock,
  input logic       meas_valid
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_code_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_sel <= 3'd5);

  assert_skip_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && skip_177 && lock && div_sel == 3'd1) |=> !lock);

  assert_lock_at_gate_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $rose(lock) |-> $past(meas_valid));

  assert_manual_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_mode |=> div_sel == (($past(man_code) > 3'd5) ? 3'd0 : $past(man_code)));

  assert_hold_code_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (auto_mode && $past(auto_mode) && !lock && !$past(lock)) |-> $stable(code_out));

  assert_step_at_gate_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (auto_mode && $past(auto_mode) && div_sel != $past(div_sel))
      |-> ($past(meas_valid) || $past(lock)));

  assert_mode_restart_R10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (auto_mode != $past(auto_mode)) |=> !lock);
endmodule

bind rate_lock_ctrl rls_checker u_rls_checker (
  .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .man_code(man_code),
  .skip_177(skip_177), .div_sel(div_sel), .code_out(code_out), .lock(lock),
  .meas_valid(meas_valid)
);

// File: tb/test_rate_lock_ctrl.sv
module test_rate_lock_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_pulse = 1'b0;
  logic       auto_mode = 1'b1;
  logic [2:0] man_code = 3'd0;
  logic       skip_177 = 1'b0;
  logic [2:0] div_sel;
  logic [2:0] code_out;
  logic       lock;
  logic       sd_flag;

  rate_lock_ctrl i_rate_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .osc_pulse(osc_pulse), .auto_mode(auto_mode),
    .man_code(man_code), .skip_177(skip_177), .div_sel(div_sel),
    .code_out(code_out), .lock(lock), .sd_flag(sd_flag)
  );

  always #10 clk = ~clk;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  int true_code = 7;
  int offs = 0;
  int acc = 0;

  logic [2:0] exp_q[$];
  bit         mon_on = 1'b0;
  bit         saw_lock = 1'b0;
  int         last_chg = 0;
  logic [2:0] prev_sel = 3'd0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int exp_count(input int code);
    return 400 + 20 * code;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // Divided-oscillator model: follows the divider select from the design.
  always @(negedge clk) begin
    int rate_num;
    if (!rst_n) begin
      acc = 0;
      osc_pulse = 1'b0;
    end else begin
      if (int'(div_sel) == true_code) rate_num = exp_count(int'(div_sel)) + offs;
      else                            rate_num = exp_count(int'(div_sel)) * 9 / 10;
      acc = acc + rate_num;
      if (acc >= 1000) begin
        acc = acc - 1000;
        osc_pulse = 1'b1;
      end else begin
        osc_pulse = 1'b0;
      end
    end
  end

  // Scoreboard monitor for the search sequence.
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      if (lock) saw_lock = 1'b1;
      if (div_sel != prev_sel) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected step", int'(div_sel), -1);
        end else begin
          logic [2:0] e;
          e = exp_q.pop_front();
          check(div_sel == e, "R2 search order", int'(div_sel), int'(e));
        end
        check(cyc - last_chg == 2000, "R9 dwell", cyc - last_chg, 2000);
        check(sd_flag == (div_sel != 3'd5), "R8 sd flag", int'(sd_flag),
              int'(div_sel != 3'd5));
        last_chg = cyc;
      end
      prev_sel = div_sel;
    end
  end

  task automatic push_seq(input bit skip, input int n);
    logic [2:0] c = 3'd0;
    for (int k = 0; k < n; k++) begin
      c = (c >= 3'd5) ? 3'd0 : c + 3'd1;
      if (skip && c == 3'd1) c = 3'd2;
      exp_q.push_back(c);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    mon_on = 1'b0;
    exp_q.delete();
    repeat (3) @(negedge clk);
    prev_sel = 3'd0;
    last_chg = 0;
    saw_lock = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    // R1: reset state
    do_reset();
    check(lock == 1'b0, "R1 lock", int'(lock), 0);
    check(div_sel == 3'd0, "R1 div_sel", int'(div_sel), 0);
    check(code_out == 3'd0, "R1 code_out", int'(code_out), 0);
    check(sd_flag == 1'b1, "R1 sd_flag", int'(sd_flag), 1);

    // R2, R8, R9: full search with no signal, including wrap
    true_code = 7;
    push_seq(1'b0, 7);
    mon_on = 1'b1;
    wait_cyc(14500);
    mon_on = 1'b0;
    check(exp_q.size() == 0, "R2 steps seen", exp_q.size(), 0);
    check(!saw_lock, "R2 no lock", int'(saw_lock), 0);

    // R3: skip 177 in auto, 177 present but never locked
    skip_177 = 1'b1;
    true_code = 1;
    offs = 0;
    do_reset();
    push_seq(1'b1, 6);
    mon_on = 1'b1;
    wait_cyc(12500);
    mon_on = 1'b0;
    check(exp_q.size() == 0, "R3 skip order", exp_q.size(), 0);
    check(!saw_lock, "R3 no lock at 177", int'(saw_lock), 0);
    skip_177 = 1'b0;

    // R4: count outside 1% does not lock, inside locks
    true_code = 0;
    offs = 6;
    do_reset();
    wait_cyc(1500);
    check(lock == 1'b0, "R4 outside 1% no lock", int'(lock), 0);
    offs = -2;
    wait_cyc(1600);
    check(lock == 1'b1, "R4 inside 1% locks", int'(lock), 1);
    check(code_out == 3'd0, "R7 code at 143", int'(code_out), 0);

    // R4: lock timing at 270 from reset
    true_code = 2;
    offs = 0;
    do_reset();
    wait_cyc(4990);
    check(lock == 1'b0, "R4 before gate end", int'(lock), 0);
    wait_cyc(20);
    check(lock == 1'b1, "R4 lock at 270", int'(lock), 1);
    check(code_out == 3'd2, "R7 code_out 270", int'(code_out), 2);
    check(sd_flag == 1'b1, "R8 sd at 270", int'(sd_flag), 1);

    // R5: hold inside 2%, drop outside
    offs = 6;
    wait_cyc(3000);
    check(lock == 1'b1, "R5 hold in 2%", int'(lock), 1);
    true_code = 7;
    wait_cyc(2100);
    check(lock == 1'b0, "R5 drop outside 2%", int'(lock), 0);
    check(div_sel == 3'd2, "R5 resume same rate", int'(div_sel), 2);
    wait_cyc(2500);
    check(code_out == 3'd2, "R7 hold while searching", int'(code_out), 2);
    check(div_sel == 3'd3, "R9 step after dwell", int'(div_sel), 3);

    // R6, R10: manual mode
    offs = 0;
    true_code = 3;
    man_code = 3'd3;
    auto_mode = 1'b0;
    wait_cyc(2500);
    check(lock == 1'b1, "R6 manual lock", int'(lock), 1);
    check(div_sel == 3'd3, "R6 manual sel", int'(div_sel), 3);
    check(code_out == 3'd3, "R6 code echo", int'(code_out), 3);
    true_code = 7;
    wait_cyc(14000);
    check(lock == 1'b0, "R6 manual unlock", int'(lock), 0);
    check(div_sel == 3'd3, "R6 no stepping", int'(div_sel), 3);

    // R8: HD rate in manual
    true_code = 5;
    man_code = 3'd5;
    wait_cyc(2500);
    check(lock == 1'b1, "R6 lock at HD", int'(lock), 1);
    check(sd_flag == 1'b0, "R8 sd low at HD", int'(sd_flag), 0);

    // R10: manual code change drops lock
    man_code = 3'd4;
    wait_cyc(2);
    check(lock == 1'b0, "R10 code change drop", int'(lock), 0);
    check(div_sel == 3'd4, "R10 new sel", int'(div_sel), 4);

    // R3: skip has no effect in manual
    skip_177 = 1'b1;
    true_code = 1;
    man_code = 3'd1;
    wait_cyc(2500);
    check(lock == 1'b1, "R3 manual 177 locks", int'(lock), 1);

    // R6: out-of-table code tried as 000
    man_code = 3'd7;
    wait_cyc(3);
    check(div_sel == 3'd0, "R6 clamp code", int'(div_sel), 0);
    check(code_out == 3'd7, "R6 echo raw code", int'(code_out), 7);

    // R10: mode change drops lock
    skip_177 = 1'b0;
    true_code = 0;
    wait_cyc(2500);
    check(lock == 1'b1, "R6 lock at clamped 143", int'(lock), 1);
    auto_mode = 1'b1;
    wait_cyc(2);
    check(lock == 1'b0, "R10 mode change drop", int'(lock), 0);

    finish_run();
  end
endmodule